// File: doc/BRIEF.md
# Privileged Status Register with Interrupt Masking

This block holds a 16-bit processor status word: a trace flag, a privilege flag, a master/interrupt flag, a three-bit interrupt priority mask and five condition-code flags. Writes pass through a privilege filter. In user mode only the condition-code byte can change. In supervisor mode every writable field can change. An exception-return path loads the whole writable word in one cycle.

The same block decides whether a pending interrupt request may be taken. A request must exceed the current mask. The top level is the exception: it ignores the mask but is taken only once per rising transition. When the sequencer opens an interrupt window and the request passes, the block raises an acknowledge for one cycle with the level it accepted. In the same clock edge it enters supervisor mode, turns tracing off, clears the master bit and raises the mask to that level. While tracing is on, each retired instruction raises a trace request one cycle later.

Top module: `sr_core`

## Requirements
- R1: After reset the word reads 0x2700 (trace 0, supervisor 1, master 0, mask 7, condition codes 0), and acknowledge and trace request are low.
- R2: Bits 14, 11, 7, 6 and 5 always read zero, even when ones are written to them. The writable mask is 0xB71F.
- R3: With `wr_sup`=1 and `wr_be[1]`=1, a write updates trace (bit 15), supervisor (bit 13), master (bit 12) and mask (bits 10..8).
- R4: With `wr_sup`=0, a write leaves bits 15..8 unchanged, and `wr_be[0]` still updates bits 4..0.
- R5: `wr_be[1]` enables the upper byte and `wr_be[0]` the lower byte. A byte whose enable is low keeps its value.
- R6: A request of level 1 to 6 is accepted in a cycle with `take_en`=1 only when its level is greater than the mask. Level 0 is never accepted.
- R7: An accept raises `irq_ack` for one cycle after the window cycle, with `irq_ack_lvl` equal to the level. In the same edge the block sets supervisor, clears trace and master, and loads the mask with the level.
- R8: Level 7 is accepted even with mask 7, once per rising transition to 7. An edge seen while `take_en` is low is held until the next window. A held level 7 gives no second accept until the request drops below 7.
- R9: `rte_ld` loads `rte_data & 0xB71F` into the word regardless of privilege, and it takes priority over the write port in the same cycle.
- R10: When trace (bit 15) is set, `instr_done` raises `trace_req` for one cycle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| wr_be | input | 2 | Byte enables: bit 1 upper, bit 0 lower |
| wr_sup | input | 1 | Privilege of the writer, 1 = supervisor |
| rte_ld | input | 1 | Exception-return load strobe |
| rte_data | input | 16 | Word restored on exception return |
| irq_lvl | input | 3 | Encoded request level, 0 = none |
| take_en | input | 1 | Interrupt entry window from the sequencer |
| instr_done | input | 1 | Instruction retire strobe |
| sr_q | output | 16 | Register contents |
| trace_en | output | 1 | Trace flag (bit 15) |
| sup_mode | output | 1 | Supervisor flag (bit 13) |
| irq_ack | output | 1 | Interrupt accepted, one-cycle pulse |
| irq_ack_lvl | output | 3 | Accepted level while `irq_ack` is high |
| trace_req | output | 1 | Trace exception request pulse |

## Verification
The bench builds the block with its defaults: edge-triggered top level and condition codes cleared on reset. This puts the once-per-edge behaviour of level 7 within reach, including an edge held over a closed window and re-arming after a drop. With the three-bit level width, the bench can sweep every mask value from 0 to 7 against every request level from 0 to 6. The level-sensitive variant is not built by the bench.

// File: rtl/sr_pkg.sv
package sr_pkg;
   localparam int SR_W    = 16;
   localparam int T_POS   = 15;
   localparam int S_POS   = 13;
   localparam int M_POS   = 12;
   localparam int IPL_LO  = 8;
   localparam int IPL_HI  = 10;
   localparam logic [7:0]  HI_WMASK = 8'hB7;
   localparam logic [7:0]  LO_WMASK = 8'h1F;
   localparam logic [15:0] WMASK    = {HI_WMASK, LO_WMASK};
   localparam logic [7:0]  HI_RST   = 8'h27;

   typedef struct packed {
      logic       trace;
      logic       rsv14;
      logic       sup;
      logic       master;
      logic       rsv11;
      logic [2:0] ipl;
   } sys_byte_t;
endpackage

// File: rtl/sr_lvl_edge.sv
module sr_lvl_edge #(
   parameter int LVL_W    = 3,
   parameter bit NMI_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] irq_lvl,
   input  logic             consume,
   output logic             top_evt
);
   localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

   logic [LVL_W-1:0] prev_q;
   logic             pend_q;
   logic             at_top;
   logic             rise;

   assign at_top = (irq_lvl == TOP);
   assign rise   = at_top && (prev_q != TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= irq_lvl;
         pend_q <= (pend_q | rise) & ~consume;
      end
   end

   generate
      if (NMI_EDGE) begin : g_edge
         assign top_evt = rise | pend_q;
      end else begin : g_level
         assign top_evt = at_top;
      end
   endgenerate
endmodule

// File: rtl/sr_mask_dec.sv
module sr_mask_dec #(
   parameter int LVL_W = 3
) (
   input  logic [LVL_W-1:0] irq_lvl,
   input  logic [LVL_W-1:0] ipl,
   input  logic             top_evt,
   input  logic             take_en,
   output logic             accept
);
   localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

   logic pass;

   always_comb begin
      if (irq_lvl == TOP)
         pass = top_evt;
      else
         pass = (irq_lvl != '0) && (irq_lvl > ipl);
   end

   assign accept = take_en & pass;
endmodule

// File: rtl/sr_fields.sv
module sr_fields
   import sr_pkg::*;
#(
   parameter int         LVL_W   = 3,
   parameter logic [4:0] CCR_RST = 5'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [15:0]      wr_data,
   input  logic [1:0]       wr_be,
   input  logic             wr_sup,
   input  logic             rte_ld,
   input  logic [15:0]      rte_data,
   input  logic             accept,
   input  logic [LVL_W-1:0] acc_lvl,
   output logic [15:0]      sr
);
   localparam logic [15:0] RST_VAL = {HI_RST, 3'b000, CCR_RST};
   localparam int          LANES   = SR_W / 8;

   logic [15:0]      sr_q;
   logic [15:0]      nxt;
   logic [LANES-1:0] lane_wr;
   sys_byte_t        hi;

   genvar b;
   generate
      for (b = 0; b < LANES; b++) begin : g_lane
         if (b == LANES - 1) begin : g_priv
            assign lane_wr[b] = wr_en & wr_be[b] & wr_sup;
         end else begin : g_open
            assign lane_wr[b] = wr_en & wr_be[b];
         end
      end
   endgenerate

   always_comb begin
      nxt = sr_q;
      if (rte_ld) begin
         nxt = rte_data & WMASK;
      end else begin
         for (int i = 0; i < LANES; i++) begin
            if (lane_wr[i])
               nxt[i*8 +: 8] = wr_data[i*8 +: 8] & WMASK[i*8 +: 8];
         end
      end
      if (accept) begin
         hi        = sys_byte_t'(nxt[15:8]);
         hi.trace  = 1'b0;
         hi.sup    = 1'b1;
         hi.master = 1'b0;
         hi.ipl    = acc_lvl;
         nxt[15:8] = hi;
      end else begin
         hi = sys_byte_t'(nxt[15:8]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= RST_VAL;
      else        sr_q <= nxt;
   end

   assign sr = sr_q;
endmodule

// File: rtl/sr_core.sv
module sr_core
   import sr_pkg::*;
#(
   parameter int         LVL_W    = 3,
   parameter bit         NMI_EDGE = 1'b1,
   parameter logic [4:0] CCR_RST  = 5'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [15:0]      wr_data,
   input  logic [1:0]       wr_be,
   input  logic             wr_sup,
   input  logic             rte_ld,
   input  logic [15:0]      rte_data,
   input  logic [LVL_W-1:0] irq_lvl,
   input  logic             take_en,
   input  logic             instr_done,
   output logic [15:0]      sr_q,
   output logic             trace_en,
   output logic             sup_mode,
   output logic             irq_ack,
   output logic [LVL_W-1:0] irq_ack_lvl,
   output logic             trace_req
);
   localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

   generate
      if (LVL_W != IPL_HI - IPL_LO + 1) begin : g_bad_width
         $error("sr_core: LVL_W must match the mask field width");
      end
   endgenerate

   logic             top_evt;
   logic             accept;
   logic [15:0]      sr;
   logic             ack_q;
   logic [LVL_W-1:0] ack_lvl_q;
   logic             trq_q;

   sr_lvl_edge #(.LVL_W(LVL_W), .NMI_EDGE(NMI_EDGE)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_lvl (irq_lvl),
      .consume (accept && (irq_lvl == TOP)),
      .top_evt (top_evt)
   );

   sr_mask_dec #(.LVL_W(LVL_W)) u_dec (
      .irq_lvl (irq_lvl),
      .ipl     (sr[IPL_HI:IPL_LO]),
      .top_evt (top_evt),
      .take_en (take_en),
      .accept  (accept)
   );

   sr_fields #(.LVL_W(LVL_W), .CCR_RST(CCR_RST)) u_fields (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .wr_be    (wr_be),
      .wr_sup   (wr_sup),
      .rte_ld   (rte_ld),
      .rte_data (rte_data),
      .accept   (accept),
      .acc_lvl  (irq_lvl),
      .sr       (sr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q     <= 1'b0;
         ack_lvl_q <= '0;
         trq_q     <= 1'b0;
      end else begin
         ack_q     <= accept;
         ack_lvl_q <= accept ? irq_lvl : '0;
         trq_q     <= sr[T_POS] & instr_done;
      end
   end

   assign sr_q        = sr;
   assign trace_en    = sr[T_POS];
   assign sup_mode    = sr[S_POS];
   assign irq_ack     = ack_q;
   assign irq_ack_lvl = ack_lvl_q;
   assign trace_req   = trq_q;
endmodule

// File: rtl/sr_chk.sv
module sr_chk #(
   parameter int LVL_W    = 3,
   parameter bit NMI_EDGE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wr_sup,
   input logic             rte_ld,
   input logic [15:0]      rte_data,
   input logic [LVL_W-1:0] irq_lvl,
   input logic             take_en,
   input logic             instr_done,
   input logic [15:0]      sr_q,
   input logic             trace_en,
   input logic             irq_ack,
   input logic [LVL_W-1:0] irq_ack_lvl,
   input logic             trace_req
);
   localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_q[14] == 1'b0) && (sr_q[11] == 1'b0) && (sr_q[7:5] == 3'b000));

   a_r4_user_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sup && !rte_ld && !take_en) |=> $stable(sr_q[15:8]));

   a_r6_level0_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (take_en && irq_lvl == '0) |=> !irq_ack);

   a_r7_ack_enters_sup: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (sr_q[13] && !sr_q[12] && !sr_q[15] && sr_q[10:8] == irq_ack_lvl));

   a_r7_ack_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
      !take_en |=> !irq_ack);

   a_r8_top_once: assert property (@(posedge clk) disable iff (!rst_n)
      (NMI_EDGE && irq_ack && irq_ack_lvl == TOP) |=> !(irq_ack && irq_ack_lvl == TOP));

   a_r9_return_load: assert property (@(posedge clk) disable iff (!rst_n)
      (rte_ld && !take_en) |=> (sr_q == ($past(rte_data) & 16'hB71F)));

   a_r10_trace_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (trace_en && instr_done) |=> trace_req);
endmodule

bind sr_core sr_chk #(.LVL_W(LVL_W), .NMI_EDGE(NMI_EDGE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_sup      (wr_sup),
   .rte_ld      (rte_ld),
   .rte_data    (rte_data),
   .irq_lvl     (irq_lvl),
   .take_en     (take_en),
   .instr_done  (instr_done),
   .sr_q        (sr_q),
   .trace_en    (trace_en),
   .irq_ack     (irq_ack),
   .irq_ack_lvl (irq_ack_lvl),
   .trace_req   (trace_req)
);

// File: tb/sr_core_tb.sv
module sr_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [1:0]  wr_be = '0;
   logic        wr_sup = 1'b0;
   logic        rte_ld = 1'b0;
   logic [15:0] rte_data = '0;
   logic [2:0]  irq_lvl = '0;
   logic        take_en = 1'b0;
   logic        instr_done = 1'b0;
   logic [15:0] sr_q;
   logic        trace_en, sup_mode, irq_ack, trace_req;
   logic [2:0]  irq_ack_lvl;

   always #4 clk = ~clk;

   sr_core u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
      .wr_sup(wr_sup), .rte_ld(rte_ld), .rte_data(rte_data), .irq_lvl(irq_lvl),
      .take_en(take_en), .instr_done(instr_done), .sr_q(sr_q), .trace_en(trace_en),
      .sup_mode(sup_mode), .irq_ack(irq_ack), .irq_ack_lvl(irq_ack_lvl),
      .trace_req(trace_req)
   );

   typedef struct {
      int          due;
      logic [15:0] sr;
      logic        ack;
      logic [2:0]  lvl;
      logic        trq;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          cyc = 0;
   int          n_cmp = 0;
   int          n_bad = 0;
   int          top_acks = 0;
   bit          done = 1'b0;
   logic [15:0] m_sr;
   logic [2:0]  m_prev;
   logic        m_pend;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
         exp_t e;
         e = sb.pop_front();
         n_cmp++;
         if (sr_q !== e.sr || irq_ack !== e.ack || irq_ack_lvl !== e.lvl ||
             trace_req !== e.trq || trace_en !== e.sr[15] || sup_mode !== e.sr[13]) begin
            n_bad++;
            $display("FAIL %s: sr=%h ack=%b lvl=%0d trq=%b expected sr=%h ack=%b lvl=%0d trq=%b",
                     e.tag, sr_q, irq_ack, irq_ack_lvl, trace_req, e.sr, e.ack, e.lvl, e.trq);
         end
         if (irq_ack === 1'b1 && irq_ack_lvl === 3'd7) top_acks++;
      end
   end

   task automatic step(input logic we, input logic [15:0] wd, input logic [1:0] be,
                       input logic sup, input logic [2:0] lvl, input logic take,
                       input logic rl, input logic [15:0] rd, input logic ret,
                       input string tag);
      exp_t        e;
      logic        e7, pend, pass, acc;
      logic [15:0] nsr;
      @(negedge clk);
      wr_en = we; wr_data = wd; wr_be = be; wr_sup = sup; irq_lvl = lvl;
      take_en = take; rte_ld = rl; rte_data = rd; instr_done = ret;
      e7   = (lvl == 3'd7) && (m_prev != 3'd7);
      pend = m_pend | e7;
      pass = (lvl == 3'd7) ? pend : ((lvl != 3'd0) && (lvl > m_sr[10:8]));
      acc  = take && pass;
      nsr  = m_sr;
      if (rl) nsr = rd & 16'hB71F;
      else if (we) begin
         if (be[1] && sup) nsr[15:8] = wd[15:8] & 8'hB7;
         if (be[0])        nsr[7:0]  = wd[7:0] & 8'h1F;
      end
      if (acc) begin
         nsr[15] = 1'b0; nsr[13] = 1'b1; nsr[12] = 1'b0; nsr[10:8] = lvl;
      end
      e.due = cyc + 1;
      e.sr  = nsr;
      e.ack = acc;
      e.lvl = acc ? lvl : 3'd0;
      e.trq = m_sr[15] && ret;
      e.tag = tag;
      sb.push_back(e);
      m_pend = pend && !(acc && lvl == 3'd7);
      m_prev = lvl;
      m_sr   = nsr;
   endtask

   task automatic idle(input logic [2:0] lvl, input logic take, input string tag);
      step(1'b0, 16'h0, 2'b00, 1'b0, lvl, take, 1'b0, 16'h0, 1'b0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      m_sr = 16'h2700; m_prev = 3'd0; m_pend = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset value seen before release
      n_cmp++;
      if (sr_q !== 16'h2700 || irq_ack !== 1'b0 || trace_req !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: sr=%h ack=%b trq=%b expected sr=2700 ack=0 trq=0", sr_q, irq_ack, trace_req);
      end
      rst_n = 1'b1;
      // R4 R2: user tries to set T/M/I and reserved bits
      step(1'b1, 16'hFFFF, 2'b11, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R4 user write ones");
      // R3 R2: supervisor full write
      step(1'b1, 16'hFFFF, 2'b11, 1'b1, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R3 sup write ones");
      // R4: user tries to clear S and I
      step(1'b1, 16'h0000, 2'b11, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R4 user clear S/I");
      // R5: lower lane only
      step(1'b1, 16'h00AA, 2'b01, 1'b1, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R5 low lane only");
      // R10: trace on, instruction retires
      step(1'b0, 16'h0, 2'b00, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 1'b1, "R10 retire traced");
      idle(3'd0, 1'b0, "R10 pulse ends");
      // R5: upper lane only, clears T and mask
      step(1'b1, 16'h20FF, 2'b10, 1'b1, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R5 high lane only");
      step(1'b0, 16'h0, 2'b00, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 1'b1, "R10 retire untraced");
      // R6 R7: every mask against levels 0..6
      for (int m = 0; m < 8; m++) begin
         for (int l = 0; l < 7; l++) begin
            step(1'b1, 16'h2000 | (16'(m) << 8), 2'b10, 1'b1, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R3 set mask");
            idle(3'(l), 1'b1, "R6 R7 mask probe");
         end
      end
      // R8: held level 7 with mask 7
      step(1'b1, 16'h3700, 2'b10, 1'b1, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R3 mask 7 master");
      for (int k = 0; k < 6; k++) idle(3'd7, 1'b1, "R8 held top level");
      idle(3'd3, 1'b1, "R8 drop below top");
      idle(3'd7, 1'b0, "R8 edge with window closed");
      idle(3'd7, 1'b0, "R8 still closed");
      idle(3'd7, 1'b1, "R8 pending edge taken");
      idle(3'd7, 1'b1, "R8 no repeat");
      idle(3'd0, 1'b0, "R8 settle");
      @(negedge clk);
      n_cmp++;
      if (top_acks != 2) begin
         n_bad++;
         $display("FAIL R8: top-level accepts=%0d expected 2", top_acks);
      end
      // R9: return load beats a same-cycle write, then restores user state
      step(1'b1, 16'h0000, 2'b11, 1'b1, 3'd0, 1'b0, 1'b1, 16'hFFFF, 1'b0, "R9 load over write");
      step(1'b0, 16'h0, 2'b00, 1'b0, 3'd0, 1'b0, 1'b1, 16'h1005, 1'b0, "R9 load user word");
      // R4: user mode cannot raise S
      step(1'b1, 16'hA71F, 2'b11, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 1'b0, "R4 user raise S");
      // R7: accept from user mode with mask 0
      idle(3'd2, 1'b1, "R7 accept from user");
      idle(3'd0, 1'b0, "R7 ack ends");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule